// File: doc/BRIEF.md
# Elapsed-Time Counter with Alarm

This block is the timekeeping core of a real-time clock. A 48-bit free-running counter advances once for every cycle in which a 32768 Hz tick enable is high, so bits 47:15 hold elapsed whole seconds and bits 14:0 hold the fraction of a second. Software reaches the counter over a 16-bit register bus as three halfword registers and can read or preset each of them.

A second 48-bit value, with the same bit layout, serves as the alarm compare value. When the counter arrives at that value, a sticky alarm flag is raised in a status register. Software clears the flag by writing a one to it. An enable register gates the flag onto the interrupt output. The block has no snapshot latch: software reads all three halves twice and keeps the value only when both reads agree.

Top module: `etc_elapsed_timer`

## Requirements
- R1: After reset the counter, the compare value, the alarm flag and the enable all read zero and irq_o is low.
- R2: Each clock cycle with tick_i high and no counter write adds one to the 48-bit counter, with carries across halfwords and wrap from all ones to zero; without a tick or a write the counter holds.
- R3: The counter reads as bits 15:0 at offset 0x00, 31:16 at 0x02 and 47:32 at 0x04, so a seconds value S written as low = S<<15, middle = S>>1, high = S>>17 reads back as S = high<<17 | middle<<1 | low>>15.
- R4: A write to a counter halfword replaces only those 16 bits at the next clock edge; in a cycle with such a write the counter does not also increment.
- R5: The compare value is written and read at offsets 0x08 (bits 15:0), 0x0a (bits 31:16) and 0x0c (bits 47:32).
- R6: When the counter becomes equal to a non-zero compare value, bit 0 of the status register at offset 0x1e reads one from the following clock cycle on.
- R7: A compare value of zero never sets the alarm flag, even when the counter passes through zero.
- R8: The alarm flag stays set after the counter moves past the match; writing 1 to status bit 0 clears it, writing 0 leaves it set.
- R9: irq_o is high exactly when the alarm flag and bit 0 of the enable register at offset 0x1a are both one.
- R10: Reads of any other offset return zero and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 32768 Hz count enable, one cycle per tick |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 5 | Byte offset of the register |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational from the offset |
| irq_o | output | 1 | Alarm interrupt |

## Verification
The bench presets halfwords close to a carry and ticks across the boundary; a design that fails to ripple the carry, or that lets a halfword write clobber its neighbours, returns a wrong upper half. It writes a halfword in a cycle with the tick high, where a design that increments as well would read one too many. For the alarm it checks that the flag is still clear right after the counter lands on the compare value and set one cycle later, that it survives further ticks and a write of zero, and that a zero compare stays silent when the counter wraps through zero, which a design without that guard would flag. Random halfword writes and tick bursts are then compared against a model of the counter.

// File: rtl/etc_pkg.sv
package etc_pkg;
  parameter int HALF_W  = 16;
  parameter int N_HALF  = 3;
  parameter int CNT_W   = HALF_W * N_HALF;
  parameter int ADDR_W  = 5;
  parameter logic [ADDR_W-1:0] CNT_BASE = 5'h00;
  parameter logic [ADDR_W-1:0] CMP_BASE = 5'h08;
  parameter logic [ADDR_W-1:0] EN_ADDR  = 5'h1a;
  parameter logic [ADDR_W-1:0] STS_ADDR = 5'h1e;
endpackage

// File: rtl/etc_counter.sv
module etc_counter #(
  parameter int HALF_W = 16,
  parameter int N_HALF = 3,
  localparam int CNT_W = HALF_W * N_HALF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [N_HALF-1:0] wr_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (|wr_i) begin
      for (int k = 0; k < N_HALF; k++)
        if (wr_i[k]) cnt_q[k*HALF_W +: HALF_W] <= wdata_i;
    end else if (tick_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;

  a_r2_tick_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && wr_i == '0) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && wr_i == '0) |=> $stable(cnt_q));
  a_r4_low_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i == N_HALF'(1)) |=> (cnt_q[HALF_W-1:0] == $past(wdata_i)
      && cnt_q[CNT_W-1:HALF_W] == $past(cnt_q[CNT_W-1:HALF_W])));
endmodule

// File: rtl/etc_alarm.sv
module etc_alarm #(
  parameter int HALF_W = 16,
  parameter int N_HALF = 3,
  localparam int CNT_W = HALF_W * N_HALF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_HALF-1:0] wr_i,
  input  logic [HALF_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [CNT_W-1:0]  cmp_o,
  output logic              hit_o
);
  logic [CNT_W-1:0] cmp_q;
  logic             match, match_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '0;
    end else begin
      for (int k = 0; k < N_HALF; k++)
        if (wr_i[k]) cmp_q[k*HALF_W +: HALF_W] <= wdata_i;
    end
  end

  // zero compare disables the alarm
  assign match = (cmp_q != '0) && (cnt_i == cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_q <= 1'b0;
    else         match_q <= match;
  end

  // one pulse on arrival, so a cleared flag is not re-raised while parked
  assign hit_o = match && !match_q;
  assign cmp_o = cmp_q;
endmodule

// File: rtl/etc_irq.sv
module etc_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_wr_i,
  input  logic en_d_i,
  output logic flag_o,
  output logic en_o,
  output logic irq_o
);
  logic flag_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (set_i)      flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
      if (en_wr_i)    en_q   <= en_d_i;
    end
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign irq_o  = flag_q & en_q;

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_q);
endmodule

// File: rtl/etc_elapsed_timer.sv
module etc_elapsed_timer
  import etc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [HALF_W-1:0] bus_wdata_i,
  output logic [HALF_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  logic [N_HALF-1:0] hit_cnt, hit_cmp;
  logic              hit_en, hit_sts, wr;
  logic [CNT_W-1:0]  cnt, cmp;
  logic              alarm_hit, flag, en;

  assign wr = bus_sel_i && bus_we_i;

  for (genvar k = 0; k < N_HALF; k++) begin : g_dec
    localparam logic [ADDR_W-1:0] CNT_A = CNT_BASE + ADDR_W'(2*k);
    localparam logic [ADDR_W-1:0] CMP_A = CMP_BASE + ADDR_W'(2*k);
    assign hit_cnt[k] = (bus_addr_i == CNT_A);
    assign hit_cmp[k] = (bus_addr_i == CMP_A);
  end
  assign hit_en  = (bus_addr_i == EN_ADDR);
  assign hit_sts = (bus_addr_i == STS_ADDR);

  etc_counter #(.HALF_W(HALF_W), .N_HALF(N_HALF)) u_cnt (
    .clk_i, .rst_ni, .tick_i,
    .wr_i    (hit_cnt & {N_HALF{wr}}),
    .wdata_i (bus_wdata_i),
    .cnt_o   (cnt)
  );

  etc_alarm #(.HALF_W(HALF_W), .N_HALF(N_HALF)) u_alarm (
    .clk_i, .rst_ni,
    .wr_i    (hit_cmp & {N_HALF{wr}}),
    .wdata_i (bus_wdata_i),
    .cnt_i   (cnt),
    .cmp_o   (cmp),
    .hit_o   (alarm_hit)
  );

  etc_irq u_irq (
    .clk_i, .rst_ni,
    .set_i   (alarm_hit),
    .clr_i   (wr && hit_sts && bus_wdata_i[0]),
    .en_wr_i (wr && hit_en),
    .en_d_i  (bus_wdata_i[0]),
    .flag_o  (flag),
    .en_o    (en),
    .irq_o   (irq_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    for (int k = 0; k < N_HALF; k++) begin
      if (hit_cnt[k]) bus_rdata_o = cnt[k*HALF_W +: HALF_W];
      if (hit_cmp[k]) bus_rdata_o = cmp[k*HALF_W +: HALF_W];
    end
    if (hit_en)  bus_rdata_o = {{(HALF_W-1){1'b0}}, en};
    if (hit_sts) bus_rdata_o = {{(HALF_W-1){1'b0}}, flag};
  end

  a_r6_flag_after_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp != '0 && cnt == cmp && !$past(cnt == cmp)) |=> flag);
  a_r7_zero_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag && cmp == '0) |=> !flag);
endmodule

// File: tb/etc_elapsed_timer_tb.sv
module etc_elapsed_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        sel = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [47:0] m_cnt = '0;

  always #10 clk = ~clk;

  etc_elapsed_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d, input logic t = 1'b0);
    sel = 1; we = 1; addr = a; wdata = d; tick = t;
    @(negedge clk);
    sel = 0; we = 0; tick = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic rd_cnt(output logic [47:0] v);
    logic [15:0] h;
    rd(5'h00, h); v[15:0]  = h;
    rd(5'h02, h); v[31:16] = h;
    rd(5'h04, h); v[47:32] = h;
  endtask

  task automatic set_cnt(input logic [47:0] v);
    wr(5'h00, v[15:0]); wr(5'h02, v[31:16]); wr(5'h04, v[47:32]);
    m_cnt = v;
  endtask

  task automatic set_cmp(input logic [47:0] v);
    wr(5'h08, v[15:0]); wr(5'h0a, v[31:16]); wr(5'h0c, v[47:32]);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1; @(negedge clk); tick = 0;
      m_cnt = m_cnt + 48'd1;
    end
  endtask

  function automatic logic [32:0] secs_of(input logic [47:0] v);
    return {v[47:32], 17'b0} | {16'b0, v[31:16], 1'b0} | 33'(v[15:0] >> 15);
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [47:0] v;
    logic [32:0] s;
    void'($urandom(32'h5eed_0042));
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd_cnt(v); chk("R1 counter", 64'(v), 0);
    rd(5'h08, d); chk("R1 compare", 64'(d), 0);
    rd(5'h1e, d); chk("R1 status", 64'(d), 0);
    rd(5'h1a, d); chk("R1 enable", 64'(d), 0);
    chk("R1 irq", 64'(irq), 0);

    // R2 basic counting
    ticks(5);
    rd_cnt(v); chk("R2 five ticks", 64'(v), 64'(m_cnt));
    repeat (3) @(negedge clk);
    rd_cnt(v); chk("R2 hold without tick", 64'(v), 64'(m_cnt));

    // R4 half writes, R2 carry ripple
    wr(5'h04, 16'h1234); m_cnt[47:32] = 16'h1234;
    rd_cnt(v); chk("R4 high only", 64'(v), 64'(m_cnt));
    wr(5'h02, 16'hffff); m_cnt[31:16] = 16'hffff;
    wr(5'h00, 16'hfffe); m_cnt[15:0]  = 16'hfffe;
    ticks(2);
    rd_cnt(v); chk("R2 carry into high", 64'(v), 64'h1235_0000_0000);

    // R4 write wins over tick
    wr(5'h00, 16'h0abc, 1'b1); m_cnt[15:0] = 16'h0abc;
    rd_cnt(v); chk("R4 write beats tick", 64'(v), 64'(m_cnt));

    // R3 seconds layout
    s = 33'h1_2345_6789;
    wr(5'h00, 16'(s << 15)); wr(5'h02, 16'(s >> 1)); wr(5'h04, 16'(s >> 17));
    m_cnt = {s, 15'b0};
    rd_cnt(v); chk("R3 seconds readback", 64'(secs_of(v)), 64'(s));
    ticks(3);
    rd_cnt(v); chk("R3 fraction ticks", 64'(v[14:0]), 3);

    // R2 R4 random mix
    for (int i = 0; i < 30; i++) begin
      int k;
      logic [15:0] rv;
      k  = int'($urandom % 3);
      rv = 16'($urandom);
      if ($urandom % 4 == 0) rv = 16'hffff;
      wr(5'(2 * k), rv);
      m_cnt[k*16 +: 16] = rv;
      ticks(int'($urandom % 4));
      rd_cnt(v); chk("R2 R4 random", 64'(v), 64'(m_cnt));
    end

    // R5 compare registers
    set_cmp(48'h00a1_b2c3_0105);
    rd(5'h08, d); chk("R5 cmp low", 64'(d), 64'h0105);
    rd(5'h0a, d); chk("R5 cmp mid", 64'(d), 64'hb2c3);
    rd(5'h0c, d); chk("R5 cmp high", 64'(d), 64'h00a1);
    set_cmp(48'h105);

    // R6 alarm timing
    wr(5'h1a, 16'h1);
    set_cnt(48'h100);
    ticks(4);
    @(negedge clk);
    rd(5'h1e, d); chk("R6 no early flag", 64'(d), 0);
    ticks(1);
    rd(5'h1e, d); chk("R6 not yet one cycle", 64'(d), 0);
    @(negedge clk);
    rd(5'h1e, d); chk("R6 flag set", 64'(d), 1);
    chk("R9 irq with enable", 64'(irq), 1);

    // R8 sticky and clear
    ticks(3);
    rd(5'h1e, d); chk("R8 sticky past match", 64'(d), 1);
    wr(5'h1e, 16'h0);
    rd(5'h1e, d); chk("R8 write zero keeps", 64'(d), 1);
    wr(5'h1e, 16'h1);
    rd(5'h1e, d); chk("R8 w1c clears", 64'(d), 0);
    chk("R9 irq low after clear", 64'(irq), 0);

    // R9 enable gating
    wr(5'h1a, 16'h0);
    set_cnt(48'h104);
    ticks(1);
    @(negedge clk);
    rd(5'h1e, d); chk("R9 flag with enable off", 64'(d), 1);
    chk("R9 irq masked", 64'(irq), 0);
    wr(5'h1a, 16'h1);
    chk("R9 irq unmasked", 64'(irq), 1);
    wr(5'h1e, 16'h1);

    // R7 zero compare, wrap through zero
    set_cmp(48'h0);
    set_cnt(48'hffff_ffff_fffe);
    ticks(3);
    repeat (2) @(negedge clk);
    rd_cnt(v); chk("R2 wrap", 64'(v), 64'(m_cnt));
    rd(5'h1e, d); chk("R7 zero compare silent", 64'(d), 0);
    chk("R7 irq silent", 64'(irq), 0);

    // R10 unmapped offsets
    wr(5'h10, 16'hbeef);
    wr(5'h06, 16'h1234);
    rd(5'h10, d); chk("R10 unmapped read 0x10", 64'(d), 0);
    rd(5'h06, d); chk("R10 unmapped read 0x06", 64'(d), 0);
    rd_cnt(v); chk("R10 counter untouched", 64'(v), 64'(m_cnt));
    rd(5'h08, d); chk("R10 compare untouched", 64'(d), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule